// File: doc/BRIEF.md
# Watchdog Recovery Sequencer

This block sits between a set of watchdog timers and the reset and boot machinery of an embedded processor subsystem. When any watchdog expires while the block is idle, it takes the processor into reset and runs one of three recovery policies. A static select input chooses the policy: cold restart, warm restart or remote image update.

- **Cold restart** reloads the first-stage boot loader into on-chip memory from the image that was already in use.
- **Warm restart** trusts the loader still held in on-chip RAM and releases the processor straight away.
- **Remote update** first wipes the programmable fabric and then reconfigures it from the next valid application image, or from the always-present factory image when no such image exists. It then loads the boot loader from that same image.

Only remote update ever touches the fabric.

Work is handed to two agents, a loader and a fabric configurator, over request/done pairs. The request is the valid side and the done pulse is the ready side. Once the block raises a request, it keeps that request and its operation and image-source fields steady until the agent answers with done. A done pulse that arrives while no request is raised has no effect.

A done that carries a failure status sends the block into a fault state. In that state the processor stays in reset until the block itself is reset. After a successful sequence, the block releases the processor, gives a one-cycle completion pulse and keeps a sticky record of which watchdog caused it.

Top module: `wdt_recovery_seq`

## Requirements
- R1: While idle, any asserted bit of `wdt_req` starts a sequence, and `cpu_rst` is high in the very next cycle. `wdt_cause` then records, as one-hot, the lowest-numbered watchdog that was asserted at that edge, and it keeps that value until the next accepted trigger.
- R2: `policy_sel` encoding is 00 cold, 01 warm and 10 remote update. The value 11 behaves exactly like cold.
- R3: Cold issues exactly one loader request, with `ldr_src` = 00 (current image). `cpu_rst` stays high until that load completes with `ldr_ok` = 1.
- R4: Warm issues no loader request and no fabric request. `cpu_rst` is high for exactly one cycle, followed by release.
- R5: Under cold and warm, `fab_req` never rises.
- R6: Remote update issues, in this order, a fabric erase (`fab_op` = 0), a fabric configure (`fab_op` = 1) and a loader request. The configure and the load use the same image source.
- R7: The remote image source is 01 (next application image) when `app_img_valid` is high at the triggering edge, and 10 (factory image) otherwise.
- R8: Once raised, `ldr_req` or `fab_req` stays high, with `ldr_src`, `fab_op` and `fab_src` unchanged, until the matching done input is seen high. At most one of the two requests is high at a time.
- R9: Watchdog requests that arrive while a sequence is running are ignored and leave `wdt_cause` unchanged. A new request is accepted again once the block is back in idle.
- R10: A done with its ok input low moves the block to a fault state. In that state `seq_err` and `cpu_rst` stay high until `rst_n` is asserted.
- R11: `seq_done` pulses high for exactly one cycle, in the first cycle that `cpu_rst` is low again after a sequence.
- R12: After reset, `cpu_rst`, `ldr_req`, `fab_req`, `seq_done` and `seq_err` are low and `wdt_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_req | input | N_WDT | Watchdog expiry requests, one per timer |
| policy_sel | input | 2 | Recovery policy: 00 cold, 01 warm, 10 remote, 11 cold |
| app_img_valid | input | 1 | A next valid application image exists |
| ldr_req | output | 1 | Request to the loader agent to load the boot loader |
| ldr_src | output | 2 | Loader image source: 00 current, 01 next application, 10 factory |
| ldr_done | input | 1 | Loader agent finished the request |
| ldr_ok | input | 1 | Loader result, sampled with `ldr_done` |
| fab_req | output | 1 | Request to the fabric configuration agent |
| fab_op | output | 1 | Fabric operation: 0 erase, 1 configure |
| fab_src | output | 2 | Fabric image source, same encoding as `ldr_src` |
| fab_done | input | 1 | Fabric agent finished the request |
| fab_ok | input | 1 | Fabric result, sampled with `fab_done` |
| cpu_rst | output | 1 | Processor held in reset while high |
| seq_done | output | 1 | One-cycle pulse when the processor is released |
| seq_err | output | 1 | Fault flag, sticky until reset |
| wdt_cause | output | N_WDT | Sticky one-hot record of the triggering watchdog |

## Verification
The bound checker watches the following on every cycle:
- reset is taken in the cycle after a trigger;
- a request and its fields hold steady until the matching done;
- the cold and warm policies keep away from the fabric;
- cold always loads from the current image;
- the cause record stays frozen while a sequence runs;
- the fault state is sticky;
- the completion pulse is one cycle long and falls in a cycle where reset is low.

Some behaviour depends on what the agents answer and on the policy chosen, so only the bench's scenarios can show it. It sweeps:
- every policy code, every single watchdog and both image-validity values, recording the order and source of each agent request;
- a failure injected at each step of the cold and remote sequences;
- a simultaneous multi-watchdog trigger;
- a burst of watchdog requests raised mid-sequence.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [1:0] {
    POL_COLD   = 2'b00,
    POL_WARM   = 2'b01,
    POL_REMOTE = 2'b10
  } policy_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_ERASE,
    S_CONFIG,
    S_LOAD,
    S_RELEASE,
    S_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    IMG_CURRENT = 2'b00,
    IMG_NEXT    = 2'b01,
    IMG_FACTORY = 2'b10
  } img_src_e;

  // Unused code 11 falls back to the cold policy.
  function automatic policy_e decode_policy(input logic [1:0] code);
    case (code)
      2'b01:   return POL_WARM;
      2'b10:   return POL_REMOTE;
      default: return POL_COLD;
    endcase
  endfunction

endpackage

// File: rtl/rcv_cause_latch.sv
module rcv_cause_latch #(
  parameter int N_WDT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [N_WDT-1:0] req,
  output logic             any_req,
  output logic [N_WDT-1:0] cause
);

  logic [N_WDT:0]   seen_below;
  logic [N_WDT-1:0] pick;

  assign seen_below[0] = 1'b0;

  // Lowest index wins when several timers expire together.
  for (genvar g = 0; g < N_WDT; g++) begin : g_prio
    assign pick[g]         = req[g] & ~seen_below[g];
    assign seen_below[g+1] = seen_below[g] | req[g];
  end

  assign any_req = seen_below[N_WDT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause <= '0;
    else if (capture) cause <= pick;
  end

endmodule

// File: rtl/rcv_policy_reg.sv
module rcv_policy_reg
  import rcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] policy_sel,
  input  logic       app_img_valid,
  output policy_e    policy,
  output img_src_e   remote_src
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      policy     <= POL_COLD;
      remote_src <= IMG_FACTORY;
    end else if (capture) begin
      policy     <= decode_policy(policy_sel);
      remote_src <= app_img_valid ? IMG_NEXT : IMG_FACTORY;
    end
  end

endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_any,
  input  policy_e    policy,
  input  img_src_e   remote_src,
  input  logic       ldr_done,
  input  logic       ldr_ok,
  input  logic       fab_done,
  input  logic       fab_ok,
  output logic       capture,
  output seq_state_e state,
  output logic       ldr_req,
  output logic       fab_req,
  output logic       fab_op,
  output img_src_e   img_sel,
  output logic       cpu_rst,
  output logic       seq_done,
  output logic       seq_err
);

  seq_state_e nxt;

  assign capture = (state == S_IDLE) && trig_any;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (trig_any) nxt = S_HOLD;
      S_HOLD: begin
        case (policy)
          POL_WARM:   nxt = S_RELEASE;
          POL_REMOTE: nxt = S_ERASE;
          default:    nxt = S_LOAD;
        endcase
      end
      S_ERASE:   if (fab_done) nxt = fab_ok ? S_CONFIG  : S_FAULT;
      S_CONFIG:  if (fab_done) nxt = fab_ok ? S_LOAD    : S_FAULT;
      S_LOAD:    if (ldr_done) nxt = ldr_ok ? S_RELEASE : S_FAULT;
      S_RELEASE: nxt = S_IDLE;
      S_FAULT:   nxt = S_FAULT;
      default:   nxt = S_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    img_sel = IMG_CURRENT;
    if (state == S_ERASE || state == S_CONFIG)
      img_sel = remote_src;
    else if (state == S_LOAD && policy == POL_REMOTE)
      img_sel = remote_src;
  end

  assign ldr_req  = (state == S_LOAD);
  assign fab_req  = (state == S_ERASE) || (state == S_CONFIG);
  assign fab_op   = (state == S_CONFIG);
  assign cpu_rst  = (state != S_IDLE) && (state != S_RELEASE);
  assign seq_done = (state == S_RELEASE);
  assign seq_err  = (state == S_FAULT);

endmodule

// File: rtl/wdt_recovery_seq.sv
module wdt_recovery_seq
  import rcv_pkg::*;
#(
  parameter int N_WDT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_WDT-1:0] wdt_req,
  input  logic [1:0]       policy_sel,
  input  logic             app_img_valid,
  output logic             ldr_req,
  output logic [1:0]       ldr_src,
  input  logic             ldr_done,
  input  logic             ldr_ok,
  output logic             fab_req,
  output logic             fab_op,
  output logic [1:0]       fab_src,
  input  logic             fab_done,
  input  logic             fab_ok,
  output logic             cpu_rst,
  output logic             seq_done,
  output logic             seq_err,
  output logic [N_WDT-1:0] wdt_cause
);

  logic       capture;
  logic       trig_any;
  policy_e    policy_q;
  img_src_e   remote_src;
  img_src_e   img_sel;
  seq_state_e seq_state;

  rcv_cause_latch #(.N_WDT(N_WDT)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .req     (wdt_req),
    .any_req (trig_any),
    .cause   (wdt_cause)
  );

  rcv_policy_reg u_policy (
    .clk           (clk),
    .rst_n         (rst_n),
    .capture       (capture),
    .policy_sel    (policy_sel),
    .app_img_valid (app_img_valid),
    .policy        (policy_q),
    .remote_src    (remote_src)
  );

  rcv_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_any   (trig_any),
    .policy     (policy_q),
    .remote_src (remote_src),
    .ldr_done   (ldr_done),
    .ldr_ok     (ldr_ok),
    .fab_done   (fab_done),
    .fab_ok     (fab_ok),
    .capture    (capture),
    .state      (seq_state),
    .ldr_req    (ldr_req),
    .fab_req    (fab_req),
    .fab_op     (fab_op),
    .img_sel    (img_sel),
    .cpu_rst    (cpu_rst),
    .seq_done   (seq_done),
    .seq_err    (seq_err)
  );

  assign ldr_src = img_sel;
  assign fab_src = img_sel;

endmodule

// File: rtl/rcv_checker.sv
module rcv_checker
  import rcv_pkg::*;
#(
  parameter int N_WDT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_WDT-1:0] wdt_req,
  input seq_state_e       state,
  input policy_e          policy,
  input logic             ldr_req,
  input logic [1:0]       ldr_src,
  input logic             ldr_done,
  input logic             fab_req,
  input logic             fab_op,
  input logic [1:0]       fab_src,
  input logic             fab_done,
  input logic             cpu_rst,
  input logic             seq_done,
  input logic             seq_err,
  input logic [N_WDT-1:0] wdt_cause
);

  p_hold_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && |wdt_req) |=> (cpu_rst && !seq_done));

  p_cause_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wdt_cause));

  p_cold_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ldr_req && policy == POL_COLD) |-> (ldr_src == 2'b00));

  p_warm_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == POL_WARM && state != S_IDLE) |-> (!ldr_req && !fab_req));

  p_no_fabric_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (policy != POL_REMOTE && state != S_IDLE) |-> !fab_req);

  p_ldr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldr_req && !ldr_done) |=> (ldr_req && $stable(ldr_src)));

  p_fab_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_req && !fab_done) |=> (fab_req && $stable(fab_op) && $stable(fab_src)));

  p_one_agent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ldr_req && fab_req));

  p_cause_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(wdt_cause));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (seq_err && cpu_rst));

  p_done_low_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !cpu_rst);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

endmodule

bind wdt_recovery_seq rcv_checker #(.N_WDT(N_WDT)) u_rcv_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdt_req   (wdt_req),
  .state     (seq_state),
  .policy    (policy_q),
  .ldr_req   (ldr_req),
  .ldr_src   (ldr_src),
  .ldr_done  (ldr_done),
  .fab_req   (fab_req),
  .fab_op    (fab_op),
  .fab_src   (fab_src),
  .fab_done  (fab_done),
  .cpu_rst   (cpu_rst),
  .seq_done  (seq_done),
  .seq_err   (seq_err),
  .wdt_cause (wdt_cause)
);

// File: tb/test_wdt_recovery_seq.sv
`timescale 1ns/1ps
module test_wdt_recovery_seq;

  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] wdt_req;
  logic [1:0]    policy_sel;
  logic          app_img_valid;
  logic          ldr_req, fab_req, fab_op;
  logic [1:0]    ldr_src, fab_src;
  logic          ldr_done, ldr_ok, fab_done, fab_ok;
  logic          cpu_rst, seq_done, seq_err;
  logic [NW-1:0] wdt_cause;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wdt_recovery_seq #(.N_WDT(NW)) i_wdt_recovery_seq (
    .clk(clk), .rst_n(rst_n), .wdt_req(wdt_req), .policy_sel(policy_sel),
    .app_img_valid(app_img_valid), .ldr_req(ldr_req), .ldr_src(ldr_src),
    .ldr_done(ldr_done), .ldr_ok(ldr_ok), .fab_req(fab_req), .fab_op(fab_op),
    .fab_src(fab_src), .fab_done(fab_done), .fab_ok(fab_ok), .cpu_rst(cpu_rst),
    .seq_done(seq_done), .seq_err(seq_err), .wdt_cause(wdt_cause)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wdt_req = '0; ldr_done = 0; ldr_ok = 0; fab_done = 0; fab_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Op code: kind*4 + source; kind 0 erase, 1 configure, 2 load.
  task automatic run_seq(input int pol, input logic [NW-1:0] reqs,
                         input bit appv, input int fail_at);
    int exp_ops[3];
    int n_exp, src, first;
    int ops[8];
    int n_ops = 0, pend = 0, rst_bad = 0;
    bit ended = 0, got_done = 0, got_err = 0;
    logic [NW-1:0] exp_cause;
    int eff;
    eff = (pol == 3) ? 0 : pol;
    src = appv ? 1 : 2;
    n_exp = 0;
    if (eff == 0) begin exp_ops[0] = 8; n_exp = 1; end
    else if (eff == 2) begin
      exp_ops[0] = 0; exp_ops[1] = 4 + src; exp_ops[2] = 8 + src; n_exp = 3;
    end
    first = -1;
    for (int i = NW - 1; i >= 0; i--) if (reqs[i]) first = i;
    exp_cause = '0;
    exp_cause[first] = 1'b1;

    policy_sel = pol[1:0];
    app_img_valid = appv;
    wdt_req = reqs;
    @(negedge clk);
    wdt_req = '0;
    check(cpu_rst == 1'b1, "R1", "cpu_rst after trigger", cpu_rst, 1);

    for (int cyc = 0; cyc < 60 && !ended; cyc++) begin
      ldr_done = 0; fab_done = 0;
      wdt_req = '0;
      if (seq_done) begin
        got_done = 1; ended = 1;
        check(!cpu_rst, "R11", "cpu_rst low at done", cpu_rst, 0);
      end else if (seq_err) begin
        got_err = 1; ended = 1;
      end else begin
        if (!cpu_rst) rst_bad++;
        if (pend == 0 && (ldr_req || fab_req)) begin
          if (ldr_req) ops[n_ops] = 8 + int'(ldr_src);
          else if (fab_op) ops[n_ops] = 4 + int'(fab_src);
          else ops[n_ops] = 0;
          n_ops++;
          pend = 2;
        end else if (pend > 0) begin
          check(ldr_req || fab_req, "R8", "request held until done", 0, 1);
          pend--;
          if (pend == 0) begin
            if (ldr_req) begin ldr_done = 1; ldr_ok = (n_ops != fail_at); end
            else begin fab_done = 1; fab_ok = (n_ops != fail_at); end
          end
        end
        if (cyc == 0) wdt_req = '1;
        @(negedge clk);
      end
    end
    wdt_req = '0; ldr_done = 0; fab_done = 0;

    check(ended, "R3", "sequence ended", ended, 1);
    check(got_done == (fail_at == 0), "R11", "done pulse seen", got_done, fail_at == 0);
    check(got_err == (fail_at != 0), "R10", "fault entered", got_err, fail_at != 0);
    check(rst_bad == 0, "R3", "cpu_rst held during work", rst_bad, 0);
    check(n_ops == ((fail_at != 0) ? fail_at : n_exp),
          (eff == 1) ? "R4" : (eff == 2 ? "R6" : "R2"), "op count",
          n_ops, (fail_at != 0) ? fail_at : n_exp);
    for (int k = 0; k < n_ops && k < n_exp; k++)
      check(ops[k] == exp_ops[k], (eff == 2) ? "R7" : "R3", "op code/source",
            ops[k], exp_ops[k]);
    if (eff != 2)
      for (int k = 0; k < n_ops; k++)
        check(ops[k] >= 8, "R5", "no fabric op", ops[k], 8);
    @(negedge clk);
    check(wdt_cause == exp_cause, "R9", "cause after mid-run requests",
          wdt_cause, exp_cause);
    if (got_err) begin
      wdt_req = '1;
      repeat (4) @(negedge clk);
      wdt_req = '0;
      check(seq_err && cpu_rst, "R10", "fault sticky", {seq_err, cpu_rst}, 3);
      do_reset();
    end else begin
      check(!seq_done && !cpu_rst, "R11", "done one cycle", seq_done, 0);
    end
  endtask

  initial begin
    policy_sel = 2'b00; app_img_valid = 1'b0;
    do_reset();
    check(!cpu_rst && !ldr_req && !fab_req && !seq_done && !seq_err,
          "R12", "outputs idle after reset", cpu_rst, 0);
    check(wdt_cause == '0, "R12", "cause cleared", wdt_cause, 0);

    for (int p = 0; p < 4; p++)
      for (int w = 0; w < NW; w++)
        for (int v = 0; v < 2; v++)
          run_seq(p, NW'(1) << w, v[0], 0);

    // Lowest-numbered watchdog recorded on simultaneous expiry.
    run_seq(1, 4'b1010, 1'b0, 0);
    check(wdt_cause == 4'b0010, "R1", "priority cause", wdt_cause, 2);

    // Failures injected at each handshake step.
    run_seq(0, 4'b0100, 1'b0, 1);
    run_seq(2, 4'b0001, 1'b1, 1);
    run_seq(2, 4'b0010, 1'b0, 2);
    run_seq(2, 4'b1000, 1'b1, 3);

    // A done with no request pending changes nothing.
    ldr_done = 1; ldr_ok = 0; fab_done = 1; fab_ok = 0;
    @(negedge clk);
    ldr_done = 0; fab_done = 0;
    @(negedge clk);
    check(!seq_err && !cpu_rst, "R8", "stray done ignored", seq_err, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule